// File: doc/BRIEF.md
# Bank Address Latch and Memory Decoder

This block sits between a 65816-class processor on an accelerator board and two memories: fast local SRAM on the board and the slow legacy system bus of the host machine. In the first half of every bus cycle (phase 2 low), the processor places the upper address byte on its data bus. The block captures that byte and joins it to the 16-bit address to form a 24-bit address. It then steers the access to local SRAM or to the legacy bus.

Any access with a nonzero bank stays on the board. For those accesses the legacy bus sees no select, a masked address and a forced read, so an address above $FFFF never aliases onto a chipset register. The legacy video DMA chip has no chip-select pin. It is kept off the bus by gating the A15 line sent to it. The block also flags a legacy access made while the core clock is set above the slow legacy rate. The clock logic can use this flag to drop the processor to 1.79 MHz.

The block is clocked by a system clock `clk` that is much faster than phase 2. The phase-2 clock is sampled as a level.

Top module: `bank_addr_decoder`

## Requirements
- R1: On every `clk` rising edge where `phi2` is low, `bank_q` loads `cpu_data`. The new value is visible after that edge.
- R2: On every `clk` rising edge where `phi2` is high, `bank_q` keeps its value, whatever `cpu_data` does.
- R3: An access is local when `bank_q` is nonzero (all 8 bits are compared). While `phi2` is high, a local access drives `sram_ce_n` low and `sys_sel` low. While `phi2` is high, a bank-0 access drives `sram_ce_n` high and `sys_sel` high.
- R4: `sram_addr` is `{bank_q[2:0], cpu_addr}`, which is 19 bits and gives a 512K space. Bank bits 3 to 7 are not part of the SRAM address.
- R5: `sram_oe_n` is low only while `phi2` is high on a local read (`cpu_rw`=1). `sram_we_n` is low only while `phi2` is high on a local write (`cpu_rw`=0). The two are never low together.
- R6: On a bank-0 access, `sys_addr` equals `cpu_addr` and `sys_rw` equals `cpu_rw`.
- R7: On a local access, `sys_addr` is forced to 16'h0000 and `sys_rw` is forced to 1 (read).
- R8: `vid_a15` equals `cpu_addr[15]` on a bank-0 access and is 0 on a local access.
- R9: `slow_req` is high only while `phi2` is high on a bank-0 access with `speed_sel` not equal to 2'b00. The speed encoding is 00 = 1.79 MHz, 01 = 7.16 MHz, 10 = 14.32 MHz, and 11 is treated as fast.
- R10: While `rst_n` is low, `bank_q` is 0 and no strobe is active.
- R11: While `phi2` is low, all of the following are inactive: `sram_ce_n`, `sram_oe_n`, `sram_we_n` (each held high), `sys_sel` and `slow_req` (each held low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, faster than phase 2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Processor phase-2 clock, sampled as a level |
| cpu_data | input | 8 | Processor data bus, which carries the bank byte while phase 2 is low |
| cpu_addr | input | 16 | Processor address A0 to A15 |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| speed_sel | input | 2 | Core clock setting: 00 slow, 01 medium, 10 fast |
| bank_q | output | 8 | Latched bank byte (A16 to A23) |
| sram_addr | output | 19 | Local SRAM address |
| sram_ce_n | output | 1 | Local SRAM chip enable, active low |
| sram_oe_n | output | 1 | Local SRAM output enable, active low |
| sram_we_n | output | 1 | Local SRAM write enable, active low |
| sys_sel | output | 1 | Legacy bus cycle select |
| sys_addr | output | 16 | Masked address toward the legacy chipset |
| sys_rw | output | 1 | Read/write toward the legacy bus, forced to read on local accesses |
| vid_a15 | output | 1 | Gated A15 toward the video DMA chip |
| slow_req | output | 1 | A legacy access is in progress while the core clock is set fast |

## Verification
The bank register is the only stored state. Every other output depends combinationally on `bank_q`, `phi2` and the live address. A new bank byte is therefore due one `clk` edge after it is driven while `phi2` is low, and the steering outputs follow in the same cycle.

The driver changes inputs on falling edges. For each half of a processor cycle it queues one expectation, and the monitor compares it a quarter period after the next rising edge. This is the first point at which the captured bank and the strobes are settled.

The hold case is covered by driving a different byte on the data bus during phase 2 high and expecting the earlier bank.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;

   // Core clock setting encoding
   localparam logic [1:0] SPD_SLOW = 2'b00;
   localparam logic [1:0] SPD_MED  = 2'b01;
   localparam logic [1:0] SPD_FAST = 2'b10;

   // Access target
   typedef enum logic {
      TGT_LEGACY = 1'b0,
      TGT_LOCAL  = 1'b1
   } target_e;

   // Strobes produced for one access
   typedef struct packed {
      logic sram_ce;
      logic sram_oe;
      logic sram_we;
      logic sys_sel;
      logic slow_req;
   } strobe_t;

endpackage

// File: rtl/bankdec_latch.sv
module bankdec_latch #(
   parameter int BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic [BANK_W-1:0] data_in,
   output logic [BANK_W-1:0] bank_q
);

   generate
      if (BANK_W < 1 || BANK_W > 8) begin : g_bad_w
         $error("bankdec_latch: BANK_W must be 1..8");
      end
   endgenerate

   // Each bit is an open window while phase 2 is low and closes on the phase-2 rise
   for (genvar b = 0; b < BANK_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     bank_q[b] <= 1'b0;
         else if (!phi2) bank_q[b] <= data_in[b];
      end
   end

   // R1
   bank_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phi2 |=> bank_q == $past(data_in));

   // R2
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phi2 |=> $stable(bank_q));

endmodule

// File: rtl/bankdec_target.sv
module bankdec_target
   import bankdec_pkg::*;
#(
   parameter int          BANK_W      = 8,
   parameter int          CPU_AW      = 16,
   parameter int          LOCAL_BITS  = 3,
   parameter bit          FULL_MATCH  = 1'b1,
   parameter logic [15:0] MASK_VALUE  = 16'h0000,
   localparam int         SRAM_AW     = CPU_AW + LOCAL_BITS
) (
   input  logic [BANK_W-1:0]  bank_q,
   input  logic [CPU_AW-1:0]  cpu_addr,
   input  logic               cpu_rw,
   output target_e            target,
   output logic [SRAM_AW-1:0] sram_addr,
   output logic [CPU_AW-1:0]  sys_addr,
   output logic               sys_rw,
   output logic               vid_a15
);

   generate
      if (LOCAL_BITS < 1 || LOCAL_BITS > BANK_W) begin : g_bad_lb
         $error("bankdec_target: LOCAL_BITS must be 1..BANK_W");
      end
      if (CPU_AW != 16) begin : g_bad_aw
         $error("bankdec_target: CPU_AW must be 16");
      end
   endgenerate

   logic local_hit;

   // Variant: compare the whole bank byte, or only the bits that reach the SRAM
   generate
      if (FULL_MATCH) begin : g_full
         assign local_hit = |bank_q;
      end else begin : g_part
         assign local_hit = |bank_q[LOCAL_BITS-1:0];
      end
   endgenerate

   assign target    = local_hit ? TGT_LOCAL : TGT_LEGACY;
   assign sram_addr = {bank_q[LOCAL_BITS-1:0], cpu_addr};

   always_comb begin
      if (local_hit) begin
         sys_addr = MASK_VALUE[CPU_AW-1:0];
         sys_rw   = 1'b1;
         vid_a15  = 1'b0;
      end else begin
         sys_addr = cpu_addr;
         sys_rw   = cpu_rw;
         vid_a15  = cpu_addr[CPU_AW-1];
      end
   end

endmodule

// File: rtl/bankdec_strobe.sv
module bankdec_strobe
   import bankdec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       phi2,
   input  target_e    target,
   input  logic       cpu_rw,
   input  logic [1:0] speed_sel,
   output strobe_t    strb
);

   logic is_local;
   assign is_local = (target == TGT_LOCAL);

   always_comb begin
      strb = '0;
      if (rst_n && phi2) begin
         strb.sram_ce  = is_local;
         strb.sram_oe  = is_local & cpu_rw;
         strb.sram_we  = is_local & ~cpu_rw;
         strb.sys_sel  = ~is_local;
         strb.slow_req = ~is_local & (speed_sel != SPD_SLOW);
      end
   end

   // R5
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(strb.sram_oe && strb.sram_we));

   // R5
   oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb.sram_oe |-> (cpu_rw && phi2));

   // R11
   low_phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phi2 |-> (strb == '0));

endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
   import bankdec_pkg::*;
#(
   parameter int          BANK_W     = 8,
   parameter int          CPU_AW     = 16,
   parameter int          LOCAL_BITS = 3,
   parameter bit          FULL_MATCH = 1'b1,
   parameter logic [15:0] MASK_VALUE = 16'h0000,
   localparam int         SRAM_AW    = CPU_AW + LOCAL_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               phi2,
   input  logic [BANK_W-1:0]  cpu_data,
   input  logic [CPU_AW-1:0]  cpu_addr,
   input  logic               cpu_rw,
   input  logic [1:0]         speed_sel,
   output logic [BANK_W-1:0]  bank_q,
   output logic [SRAM_AW-1:0] sram_addr,
   output logic               sram_ce_n,
   output logic               sram_oe_n,
   output logic               sram_we_n,
   output logic               sys_sel,
   output logic [CPU_AW-1:0]  sys_addr,
   output logic               sys_rw,
   output logic               vid_a15,
   output logic               slow_req
);

   target_e tgt;
   strobe_t strb;

   bankdec_latch #(.BANK_W(BANK_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .phi2    (phi2),
      .data_in (cpu_data),
      .bank_q  (bank_q)
   );

   bankdec_target #(
      .BANK_W     (BANK_W),
      .CPU_AW     (CPU_AW),
      .LOCAL_BITS (LOCAL_BITS),
      .FULL_MATCH (FULL_MATCH),
      .MASK_VALUE (MASK_VALUE)
   ) u_target (
      .bank_q    (bank_q),
      .cpu_addr  (cpu_addr),
      .cpu_rw    (cpu_rw),
      .target    (tgt),
      .sram_addr (sram_addr),
      .sys_addr  (sys_addr),
      .sys_rw    (sys_rw),
      .vid_a15   (vid_a15)
   );

   bankdec_strobe u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .phi2      (phi2),
      .target    (tgt),
      .cpu_rw    (cpu_rw),
      .speed_sel (speed_sel),
      .strb      (strb)
   );

   assign sram_ce_n = ~strb.sram_ce;
   assign sram_oe_n = ~strb.sram_oe;
   assign sram_we_n = ~strb.sram_we;
   assign sys_sel   = strb.sys_sel;
   assign slow_req  = strb.slow_req;

   // R3
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phi2 |-> (sys_sel != !sram_ce_n));

   // R7
   chipset_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_q != '0) |-> (sys_addr == MASK_VALUE[CPU_AW-1:0] && sys_rw && !sys_sel && !vid_a15));

   // R9
   slow_only_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slow_req |-> (sys_sel && speed_sel != SPD_SLOW));

endmodule

// File: tb/bank_addr_decoder_tb.sv
module bank_addr_decoder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      logic [7:0]  bank;
      logic [18:0] sram_addr;
      logic        ce_n, oe_n, we_n, sys_sel, sys_rw, vid_a15, slow_req;
      logic [15:0] sys_addr;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phi2 = 1'b0;
   logic [7:0]  cpu_data = 8'h00;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_rw = 1'b1;
   logic [1:0]  speed_sel = 2'b00;

   logic [7:0]  bank_q;
   logic [18:0] sram_addr;
   logic        sram_ce_n, sram_oe_n, sram_we_n, sys_sel, sys_rw, vid_a15, slow_req;
   logic [15:0] sys_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_addr_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_data(cpu_data),
      .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .speed_sel(speed_sel),
      .bank_q(bank_q), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
      .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sys_sel(sys_sel),
      .sys_addr(sys_addr), .sys_rw(sys_rw), .vid_a15(vid_a15), .slow_req(slow_req)
   );

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Expected outputs from the requirements; hi selects phase-2 high
   function automatic exp_t model(input logic [7:0] bank, input logic [15:0] addr,
                                  input logic rw, input logic [1:0] spd, input bit hi,
                                  input string tag);
      exp_t e;
      logic loc;
      loc         = (bank != 8'h00);
      e.bank      = bank;
      e.sram_addr = {bank[2:0], addr};
      e.sys_addr  = loc ? 16'h0000 : addr;
      e.sys_rw    = loc ? 1'b1 : rw;
      e.vid_a15   = loc ? 1'b0 : addr[15];
      e.ce_n      = !(hi && loc);
      e.oe_n      = !(hi && loc && rw);
      e.we_n      = !(hi && loc && !rw);
      e.sys_sel   = hi && !loc;
      e.slow_req  = hi && !loc && (spd != 2'b00);
      e.tag       = tag;
      return e;
   endfunction

   // Driver: one processor cycle with two queued expectations
   task automatic run_cycle(input logic [7:0] bank, input logic [15:0] addr, input logic rw,
                            input logic [1:0] spd, input logic [7:0] hi_data, input string tag);
      @(negedge clk);
      phi2 = 1'b0; cpu_data = bank; cpu_addr = addr; cpu_rw = rw; speed_sel = spd;
      @(negedge clk);
      exp_q.push_back(model(bank, addr, rw, spd, 1'b0, {tag, "/lo"}));
      @(negedge clk);
      phi2 = 1'b1; cpu_data = hi_data;
      exp_q.push_back(model(bank, addr, rw, spd, 1'b1, {tag, "/hi"}));
      @(negedge clk);
   endtask

   // Monitor: compare a quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            // R1 R2 bank capture and hold
            check({"R1/R2 ", e.tag}, "bank_q", 32'(bank_q), 32'(e.bank));
            // R4
            check({"R4 ", e.tag}, "sram_addr", 32'(sram_addr), 32'(e.sram_addr));
            // R3 R11
            check({"R3/R11 ", e.tag}, "sram_ce_n", 32'(sram_ce_n), 32'(e.ce_n));
            check({"R3/R11 ", e.tag}, "sys_sel", 32'(sys_sel), 32'(e.sys_sel));
            // R5
            check({"R5 ", e.tag}, "sram_oe_n", 32'(sram_oe_n), 32'(e.oe_n));
            check({"R5 ", e.tag}, "sram_we_n", 32'(sram_we_n), 32'(e.we_n));
            // R6 R7
            check({"R6/R7 ", e.tag}, "sys_addr", 32'(sys_addr), 32'(e.sys_addr));
            check({"R6/R7 ", e.tag}, "sys_rw", 32'(sys_rw), 32'(e.sys_rw));
            // R8
            check({"R8 ", e.tag}, "vid_a15", 32'(vid_a15), 32'(e.vid_a15));
            // R9
            check({"R9 ", e.tag}, "slow_req", 32'(slow_req), 32'(e.slow_req));
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      phi2 = 1'b1;
      cpu_data = 8'h5A;
      repeat (3) @(negedge clk);
      // R10 reset state, with phase 2 high and junk on the bus
      check("R10", "bank_q", 32'(bank_q), 32'h0);
      check("R10", "sram_ce_n", 32'(sram_ce_n), 32'h1);
      check("R10", "sram_we_n", 32'(sram_we_n), 32'h1);
      check("R10", "sys_sel", 32'(sys_sel), 32'h0);
      check("R10", "slow_req", 32'(slow_req), 32'h0);
      rst_n = 1'b1;

      // R6 R8 legacy read in the video chip range at the slow rate
      run_cycle(8'h00, 16'hD40A, 1'b1, 2'b00, 8'hC3, "legacy rd slow");
      // R9 legacy write at the medium rate
      run_cycle(8'h00, 16'h8000, 1'b0, 2'b01, 8'h77, "legacy wr med");
      // R3 R5 local read, with other data in phase 2 high (R2)
      run_cycle(8'h03, 16'h1234, 1'b1, 2'b10, 8'h00, "local rd b3");
      // R5 local write at the top of bank 7
      run_cycle(8'h07, 16'hFFFF, 1'b0, 2'b00, 8'hFF, "local wr b7");
      // R7 R8 local access shadowing the video chip address
      run_cycle(8'h01, 16'hD400, 1'b0, 2'b10, 8'h00, "local shadow");
      // R4 bank 8 is local, and only bits 2:0 reach the SRAM
      run_cycle(8'h08, 16'h4321, 1'b1, 2'b00, 8'h00, "bank8 alias");
      // R3 R4 high bank bit only
      run_cycle(8'h80, 16'h0042, 1'b1, 2'b01, 8'h00, "bank80");
      // R8 legacy with A15 low; R9 with fast code 11
      run_cycle(8'h00, 16'h7FFF, 1'b0, 2'b11, 8'h12, "legacy a15lo");
      // R1 the bank changes back to zero after a local cycle
      run_cycle(8'h05, 16'hABCD, 1'b1, 2'b10, 8'h00, "local b5");
      run_cycle(8'h00, 16'hABCD, 1'b1, 2'b10, 8'h05, "legacy fast");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule